// File: doc/BRIEF.md
# Variable-Width Retire Control Queue

This block keeps the program-order record of instructions in flight in an out-of-order core and retires them in order. Each dispatched instruction claims as many reorder entries as it has micro-operations (possibly none) and is written into one slot of a circular ring. The dispatch port hands back a token, which is the ring slot index holding the instruction. Execution units later return that token on the completion port, and the slot is marked done.

The ring has twice as many slots as there are reorder entries. An instruction advances the write pointer by its micro-operation count, or by one when the count is zero. The slot index and the free-entry count are therefore tracked separately. Each cycle, retirement starts at the oldest slot and walks forward over consecutive completed slots. It stops at the first slot that has not completed, or at a parameterised lane limit, where a limit of zero means no limit. Retired slots are emptied and their entries are returned to the free count.

Top module: `retire_queue`

## Requirements
- R1: After reset, the free-entry count equals ENTRIES, no retire lane is valid, no error is raised, and the first dispatch receives token 0.
- R2: An accepted dispatch receives the current write slot as its token. The write slot then advances by max(1, micro-op count), modulo 2*ENTRIES.
- R3: dispReady is low when the requested micro-op count exceeds the free-entry count, or when fewer ring slots are free than max(1, count). A dispatch offered while dispReady is low changes nothing.
- R4: The free-entry count drops by the micro-op count of an accepted dispatch and rises by the stored count of each retired instruction. A zero-count instruction leaves the count unchanged, and the count never exceeds ENTRIES.
- R5: Retirement is strictly in dispatch order. Nothing retires while the oldest occupied slot has not completed, whatever the state of younger slots.
- R6: At most MAX_RETIRE instructions retire per cycle (all ring slots when MAX_RETIRE is 0). Valid lanes are packed from lane 0, and lane 0 holds the oldest instruction.
- R7: A completion whose token names an empty slot, or a slot already marked complete, raises exeError in the same cycle (combinationally) and changes no state.
- R8: A completion and retirements in the same cycle are both carried out. A slot completed in cycle N can retire in cycle N+1 at the earliest.
- R9: Each valid retire lane carries the tag that was given at dispatch for that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| dispValid | input | 1 | Dispatch request |
| dispUops | input | UOP_W | Micro-op count of the dispatched instruction |
| dispTag | input | TAG_W | Instruction tag stored with the slot |
| dispToken | output | IDX_W | Slot index given to the dispatched instruction |
| dispReady | output | 1 | Dispatch is accepted this cycle |
| exeValid | input | 1 | Completion pulse |
| exeToken | input | IDX_W | Slot index of the completed instruction |
| exeError | output | 1 | Completion names an empty or already-complete slot |
| retValid | output | LANES | Per-lane retire strobe, lane 0 oldest |
| retTag | output | LANES x TAG_W | Tag of each retiring instruction |
| freeCount | output | CNT_W | Unreserved reorder entries |

## Verification
The following outputs are combinational functions of the registered state and the current inputs, so they are due in the cycle the stimulus is applied: dispReady, dispToken, exeError, and the retire lanes. The effects of a dispatch, a completion or a retirement on freeCount and on later retire lanes appear one clock edge later, so a completion shows up as a retirement no sooner than the next cycle. The bench drives each cycle at the falling edge. It compares all outputs shortly afterwards against an arithmetic model of the ring, and only then advances that model by one edge, so every result is checked in the cycle it is due.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef struct packed {
    logic wrSlot;
    logic markExe;
  } rqStrobe_t;
endpackage

// File: rtl/rq_store.sv
module rq_store import rq_pkg::*; #(
  parameter int SLOTS = 8,
  parameter int IDX_W = 3,
  parameter int UOP_W = 3,
  parameter int TAG_W = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  rqStrobe_t                         strobe,
  input  logic [IDX_W-1:0]                  wrIdx,
  input  logic [UOP_W-1:0]                  wrCnt,
  input  logic [TAG_W-1:0]                  wrTag,
  input  logic [IDX_W-1:0]                  exeIdx,
  input  logic [SLOTS-1:0]                  clrMask,
  output logic [SLOTS-1:0]                  occVec,
  output logic [SLOTS-1:0]                  exeVec,
  output logic [SLOTS-1:0][UOP_W-1:0]       cntVec,
  output logic [SLOTS-1:0][TAG_W-1:0]       tagVec
);
  for (genvar s = 0; s < SLOTS; s++) begin : gSlot
    logic wrHit;
    logic exeHit;
    assign wrHit  = strobe.wrSlot && (wrIdx == IDX_W'(s));
    assign exeHit = strobe.markExe && (exeIdx == IDX_W'(s));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        occVec[s] <= 1'b0;
        exeVec[s] <= 1'b0;
        cntVec[s] <= '0;
        tagVec[s] <= '0;
      end else if (wrHit) begin
        occVec[s] <= 1'b1;
        exeVec[s] <= 1'b0;
        cntVec[s] <= wrCnt;
        tagVec[s] <= wrTag;
      end else if (clrMask[s]) begin
        occVec[s] <= 1'b0;
        exeVec[s] <= 1'b0;
      end else if (exeHit) begin
        exeVec[s] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rq_ctrl.sv
module rq_ctrl import rq_pkg::*; #(
  parameter int ENTRIES = 4,
  parameter int SLOTS   = 8,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 3,
  parameter int SCNT_W  = 4,
  parameter int UOP_W   = 3,
  parameter int TAG_W   = 8,
  parameter int LANES   = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         dispValid,
  input  logic [UOP_W-1:0]             dispUops,
  input  logic                         exeValid,
  input  logic [IDX_W-1:0]             exeToken,
  input  logic [SLOTS-1:0]             occVec,
  input  logic [SLOTS-1:0]             exeVec,
  input  logic [SLOTS-1:0][UOP_W-1:0]  cntVec,
  input  logic [SLOTS-1:0][TAG_W-1:0]  tagVec,
  output rqStrobe_t                    strobe,
  output logic [IDX_W-1:0]             wrIdx,
  output logic [SLOTS-1:0]             clrMask,
  output logic                         dispReady,
  output logic [IDX_W-1:0]             dispToken,
  output logic                         exeError,
  output logic [LANES-1:0]             retValid,
  output logic [LANES-1:0][TAG_W-1:0]  retTag,
  output logic [CNT_W-1:0]             freeCount,
  output logic [IDX_W-1:0]             headIdx
);
  localparam int SW = IDX_W + UOP_W + 1;
  localparam logic [SW-1:0] RING = SW'(SLOTS);

  logic [IDX_W-1:0]  tailIdx;
  logic [IDX_W-1:0]  headNext;
  logic [SCNT_W-1:0] slotsFree;
  logic [31:0]       freedEnt;
  logic [31:0]       freedSlots;
  logic              accept;

  function automatic logic [UOP_W-1:0] stepOf(input logic [UOP_W-1:0] n);
    return (n == '0) ? UOP_W'(1) : n;
  endfunction

  function automatic logic [IDX_W-1:0] advance(input logic [IDX_W-1:0] idx,
                                               input logic [UOP_W-1:0] n);
    logic [SW-1:0] sum;
    sum = SW'(idx) + SW'(stepOf(n));
    if (sum >= RING) sum = sum - RING;
    return sum[IDX_W-1:0];
  endfunction

  // dispatch side
  assign dispReady = (32'(dispUops) <= 32'(freeCount)) &&
                     (32'(stepOf(dispUops)) <= 32'(slotsFree));
  assign accept    = dispValid && dispReady;
  assign dispToken = tailIdx;
  assign wrIdx     = tailIdx;

  // completion side
  assign exeError       = exeValid && (!occVec[exeToken] || exeVec[exeToken]);
  assign strobe.wrSlot  = accept;
  assign strobe.markExe = exeValid && !exeError;

  // in-order retirement walk from the head
  always_comb begin
    logic [IDX_W-1:0] ptr;
    logic             go;
    ptr        = headIdx;
    go         = 1'b1;
    freedEnt   = '0;
    freedSlots = '0;
    clrMask    = '0;
    retValid   = '0;
    retTag     = '0;
    for (int l = 0; l < LANES; l++) begin
      if (go && occVec[ptr] && exeVec[ptr]) begin
        retValid[l]  = 1'b1;
        retTag[l]    = tagVec[ptr];
        clrMask[ptr] = 1'b1;
        freedEnt     = freedEnt + 32'(cntVec[ptr]);
        freedSlots   = freedSlots + 32'(stepOf(cntVec[ptr]));
        ptr          = advance(ptr, cntVec[ptr]);
      end else begin
        go = 1'b0;
      end
    end
    headNext = ptr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx   <= '0;
      tailIdx   <= '0;
      freeCount <= CNT_W'(ENTRIES);
      slotsFree <= SCNT_W'(SLOTS);
    end else begin
      headIdx <= headNext;
      if (accept) tailIdx <= advance(tailIdx, dispUops);
      freeCount <= CNT_W'(32'(freeCount) + freedEnt -
                          (accept ? 32'(dispUops) : 32'd0));
      slotsFree <= SCNT_W'(32'(slotsFree) + freedSlots -
                           (accept ? 32'(stepOf(dispUops)) : 32'd0));
    end
  end
endmodule

// File: rtl/retire_queue.sv
module retire_queue import rq_pkg::*; #(
  parameter  int ENTRIES    = 4,
  parameter  int MAX_RETIRE = 2,
  parameter  int UOP_W      = 3,
  parameter  int TAG_W      = 8,
  localparam int SLOTS      = 2 * ENTRIES,
  localparam int IDX_W      = $clog2(SLOTS),
  localparam int CNT_W      = $clog2(ENTRIES + 1),
  localparam int SCNT_W     = $clog2(SLOTS + 1),
  localparam int LANES      = (MAX_RETIRE == 0 || MAX_RETIRE > SLOTS) ? SLOTS : MAX_RETIRE
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         dispValid,
  input  logic [UOP_W-1:0]             dispUops,
  input  logic [TAG_W-1:0]             dispTag,
  output logic [IDX_W-1:0]             dispToken,
  output logic                         dispReady,
  input  logic                         exeValid,
  input  logic [IDX_W-1:0]             exeToken,
  output logic                         exeError,
  output logic [LANES-1:0]             retValid,
  output logic [LANES-1:0][TAG_W-1:0]  retTag,
  output logic [CNT_W-1:0]             freeCount
);
  rqStrobe_t                   strobe;
  logic [IDX_W-1:0]            wrIdx;
  logic [IDX_W-1:0]            headIdx;
  logic [SLOTS-1:0]            clrMask;
  logic [SLOTS-1:0]            occVec;
  logic [SLOTS-1:0]            exeVec;
  logic [SLOTS-1:0][UOP_W-1:0] cntVec;
  logic [SLOTS-1:0][TAG_W-1:0] tagVec;

  rq_ctrl #(
    .ENTRIES(ENTRIES), .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W),
    .SCNT_W(SCNT_W), .UOP_W(UOP_W), .TAG_W(TAG_W), .LANES(LANES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispUops(dispUops),
    .exeValid(exeValid), .exeToken(exeToken), .occVec(occVec),
    .exeVec(exeVec), .cntVec(cntVec), .tagVec(tagVec), .strobe(strobe),
    .wrIdx(wrIdx), .clrMask(clrMask), .dispReady(dispReady),
    .dispToken(dispToken), .exeError(exeError), .retValid(retValid),
    .retTag(retTag), .freeCount(freeCount), .headIdx(headIdx)
  );

  rq_store #(
    .SLOTS(SLOTS), .IDX_W(IDX_W), .UOP_W(UOP_W), .TAG_W(TAG_W)
  ) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx),
    .wrCnt(dispUops), .wrTag(dispTag), .exeIdx(exeToken),
    .clrMask(clrMask), .occVec(occVec), .exeVec(exeVec),
    .cntVec(cntVec), .tagVec(tagVec)
  );
endmodule

// File: rtl/rq_checker.sv
module rq_checker #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 3,
  parameter int UOP_W   = 3,
  parameter int LANES   = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             dispValid,
  input logic [UOP_W-1:0] dispUops,
  input logic             dispReady,
  input logic             exeValid,
  input logic [IDX_W-1:0] exeToken,
  input logic             exeError,
  input logic [LANES-1:0] retValid,
  input logic [CNT_W-1:0] freeCount,
  input logic [IDX_W-1:0] headIdx
);
  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (32'(freeCount) == 32'(ENTRIES)) && (retValid == '0)); // R1

  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && (32'(dispUops) > 32'(freeCount)) |-> !dispReady); // R3

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    32'(freeCount) <= 32'(ENTRIES)); // R4

  AST_FREE_DISPATCH: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && dispReady && (retValid == '0) |=>
      32'(freeCount) == 32'($past(freeCount)) - 32'($past(dispUops))); // R4

  AST_NO_RETIRE_NO_GAIN: assert property (@(posedge clk) disable iff (!rstN)
    (retValid == '0) |=> 32'(freeCount) <= 32'($past(freeCount))); // R5

  AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rstN)
    (retValid & (retValid + 1'b1)) == '0); // R6

  AST_COMPLETE_NOT_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    exeValid && !exeError && (exeToken == headIdx) |-> !retValid[0]); // R8
endmodule

bind retire_queue rq_checker #(
  .ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W), .UOP_W(UOP_W), .LANES(LANES)
) uChk (
  .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispUops(dispUops),
  .dispReady(dispReady), .exeValid(exeValid), .exeToken(exeToken),
  .exeError(exeError), .retValid(retValid), .freeCount(freeCount),
  .headIdx(headIdx)
);

// File: tb/tb_retire_queue.sv
`timescale 1ns/1ps
module tb_retire_queue;
  localparam int ENTRIES = 4;
  localparam int SLOTS   = 8;
  localparam int LANES   = 2;

  logic            clk = 1'b0;
  logic            rstN;
  logic            dispValid;
  logic [2:0]      dispUops;
  logic [7:0]      dispTag;
  logic [2:0]      dispToken;
  logic            dispReady;
  logic            exeValid;
  logic [2:0]      exeToken;
  logic            exeError;
  logic [1:0]      retValid;
  logic [1:0][7:0] retTag;
  logic [2:0]      freeCount;

  always #2 clk = ~clk;

  retire_queue dut (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispUops(dispUops),
    .dispTag(dispTag), .dispToken(dispToken), .dispReady(dispReady),
    .exeValid(exeValid), .exeToken(exeToken), .exeError(exeError),
    .retValid(retValid), .retTag(retTag), .freeCount(freeCount)
  );

  int nChecks = 0;
  int nFails  = 0;

  // reference model of the ring
  int mOcc[SLOTS];
  int mExe[SLOTS];
  int mCnt[SLOTS];
  int mTag[SLOTS];
  int mHead = 0;
  int mTail = 0;
  int mFree = ENTRIES;
  int mSlots = SLOTS;
  int lastTok;
  bit lastAcc;

  function automatic int stp(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit dv, input int du, input int dt, input bit ev, input int et);
    int  ptr;
    bit  go;
    bit  eReady;
    bit  eErr;
    int  expV;
    int  expT[LANES];
    @(negedge clk);
    dispValid = dv; dispUops = 3'(du); dispTag = 8'(dt);
    exeValid = ev;  exeToken = 3'(et);
    #1;
    check(int'(freeCount) == mFree, "R4 free-entry count", int'(freeCount), mFree);
    eReady = (du <= mFree) && (stp(du) <= mSlots);
    if (dv) begin
      check(dispReady == eReady, "R3 dispatch ready", int'(dispReady), int'(eReady));
      check(int'(dispToken) == mTail, "R2 token is write slot", int'(dispToken), mTail);
    end
    eErr = ev && ((mOcc[et] == 0) || (mExe[et] == 1));
    check(exeError == eErr, "R7 completion error", int'(exeError), int'(eErr));
    // retirement walk
    ptr = mHead; go = 1'b1; expV = 0;
    for (int l = 0; l < LANES; l++) begin
      expT[l] = 0;
      if (go && mOcc[ptr] == 1 && mExe[ptr] == 1) begin
        expV = expV | (1 << l);
        expT[l] = mTag[ptr];
        mOcc[ptr] = 0; mExe[ptr] = 0;
        mFree  += mCnt[ptr];
        mSlots += stp(mCnt[ptr]);
        ptr = (ptr + stp(mCnt[ptr])) % SLOTS;
      end else go = 1'b0;
    end
    mHead = ptr;
    check(int'(retValid) == expV, "R5 R6 R8 retire lanes", int'(retValid), expV);
    for (int l = 0; l < LANES; l++)
      if ((expV >> l) & 1)
        check(int'(retTag[l]) == expT[l], "R9 retire tag", int'(retTag[l]), expT[l]);
    if (ev && !eErr) mExe[et] = 1;
    lastAcc = dv && eReady;
    lastTok = mTail;
    if (dv && eReady) begin
      mOcc[mTail] = 1; mExe[mTail] = 0; mCnt[mTail] = du; mTag[mTail] = dt;
      mFree  -= du;
      mSlots -= stp(du);
      mTail = (mTail + stp(du)) % SLOTS;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  function automatic int pickPending(input int start);
    for (int i = 0; i < SLOTS; i++) begin
      int s = (start + i) % SLOTS;
      if (mOcc[s] == 1 && mExe[s] == 0) return s;
    end
    return -1;
  endfunction

  initial begin
    int toks[8];
    for (int i = 0; i < SLOTS; i++) begin
      mOcc[i] = 0; mExe[i] = 0; mCnt[i] = 0; mTag[i] = 0;
    end
    rstN = 1'b0; dispValid = 0; dispUops = 0; dispTag = 0; exeValid = 0; exeToken = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1: reset state
    check(int'(freeCount) == ENTRIES, "R1 reset free count", int'(freeCount), ENTRIES);
    check(retValid == 2'b00, "R1 reset retire lanes", int'(retValid), 0);
    check(exeError == 1'b0, "R1 reset error", int'(exeError), 0);
    dispValid = 1; dispUops = 3'd4;
    #0.5;
    check(dispReady == 1'b1, "R1 reset ready full budget", int'(dispReady), 1);
    check(dispToken == 3'd0, "R1 reset first token", int'(dispToken), 0);
    dispValid = 0;

    // single-instruction sweep over every micro-op count (R2 R3 R4 R9)
    for (int n = 0; n < 8; n++) begin
      step(1, n, 8'h10 + n, 0, 0);
      if (lastAcc) begin
        int t = lastTok;
        idle(1);
        step(0, 0, 0, 1, t);
        idle(2);
      end
    end

    // fill with single-entry instructions, complete youngest first (R3 R5 R6)
    for (int i = 0; i < 4; i++) begin step(1, 1, 8'h20 + i, 0, 0); toks[i] = lastTok; end
    step(1, 1, 8'h2f, 0, 0);                 // refused: budget exhausted
    for (int i = 3; i >= 1; i--) step(0, 0, 0, 1, toks[i]);
    idle(1);                                  // head not done: nothing retires
    step(0, 0, 0, 1, toks[0]);
    idle(3);

    // bad completions (R7)
    step(0, 0, 0, 1, mTail);                  // empty slot
    step(1, 2, 8'h31, 0, 0); toks[0] = lastTok;
    step(0, 0, 0, 1, toks[0]);
    step(0, 0, 0, 1, toks[0]);                // already executed (retiring now)
    idle(2);

    // zero-count flood exhausts ring slots, not entries (R3 R4)
    for (int i = 0; i < 9; i++) begin step(1, 0, 8'h40 + i, 0, 0); toks[i % 8] = lastTok; end
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, (mHead + i) % SLOTS);
    idle(5);

    // same-cycle completion and retirement (R8)
    step(1, 1, 8'h51, 0, 0); toks[0] = lastTok;
    step(1, 2, 8'h52, 0, 0); toks[1] = lastTok;
    step(0, 0, 0, 1, toks[0]);
    step(0, 0, 0, 1, toks[1]);                // head retires this cycle
    idle(2);

    // long mixed run
    for (int c = 0; c < 3000; c++) begin
      bit dv = ($urandom % 3) != 0;
      int du = $urandom % 5;
      bit ev = ($urandom % 2) == 1;
      int et = $urandom % SLOTS;
      int p  = pickPending($urandom % SLOTS);
      if (p >= 0 && ($urandom % 8) != 0) et = p;
      step(dv, du, $urandom % 256, ev, et);
    end
    idle(10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule